// File: doc/BRIEF.md
# Programmable Clock-Enable Divider Bank

This block turns one main clock into four lower-rate strobes. Each strobe is a tick that is high for one cycle. Software sets the divide ratios through a small byte-wide register port with an address, write data, a write strobe and read data. Three registers are visible on that port. The fast register holds a 4-bit fast divisor and a 3-bit multiplier-mode code. The slow register holds one 8-bit divisor. The auxiliary register packs two 4-bit divisors.

Three of the dividers divide by their field plus one. The slow divider divides by twice its field plus one, so its tick period is always even. The mode code is decoded into a multiplier value: 3, 4 or 5, or 0 with an invalid flag for codes that have no meaning. That value goes to an external frequency synthesiser, which is not part of this block. While the system clock is taken from that synthesiser, the mode code is locked against writes. An input tells the block which clock source is selected.

Writing a register clears the counters of the dividers it controls. A new divisor therefore starts with a full period, measured from the write.

Top module: `clk_prescaler_bank`

## Requirements
- R1: After reset, reads return 0x4F at address 0, 0xB6 at address 1 and 0xFF at address 2.
- R2: At address 0, bits 3:0 hold the fast divisor and bits 6:4 hold the mode code. Bit 7 is not stored and always reads 0.
- R3: tick_fast is high one cycle in every (fast divisor + 1). A divisor of 0 keeps tick_fast high on every cycle.
- R4: tick_slow is high one cycle in every 2 x (slow divisor + 1), where the slow divisor is the 8-bit value at address 1. A divisor of 0 gives a tick every 2 cycles.
- R5: At address 2, bits 3:0 are auxiliary divisor 1 and bits 7:4 are auxiliary divisor 2. tick_aux1 fires every (divisor 1 + 1) cycles and tick_aux2 fires every (divisor 2 + 1) cycles.
- R6: A write to address 0 while pll_src_sel is 1 leaves the mode code unchanged. The fast divisor is still updated.
- R7: pll_mult reports 3 for mode code 3'b011, 4 for 3'b100 and 5 for 3'b101, and pll_mode_bad is then 0.
- R8: Every other mode code (000, 001, 010, 110, 111) gives pll_mult = 0 and pll_mode_bad = 1.
- R9: A write clears the counters of the dividers that register controls. With period P, the first tick comes P-1 clock edges after the write edge.
- R10: Address 3 reads as 0x00, and a write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address (0 fast, 1 slow, 2 auxiliary, 3 unused) |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pll_src_sel | input | 1 | 1 while the system clock comes from the synthesiser; locks the mode code |
| tick_fast | output | 1 | Fast divided tick |
| tick_slow | output | 1 | Slow divided tick |
| tick_aux1 | output | 1 | Auxiliary tick 1 |
| tick_aux2 | output | 1 | Auxiliary tick 2 |
| pll_mult | output | 3 | Decoded multiplier (3, 4, 5, or 0 when invalid) |
| pll_mode_bad | output | 1 | High when the mode code is a reserved value |

## Verification
The hardest case to reach from the ports is a write that lands in the middle of a long period. The counter must restart from zero at that edge, not finish the old period. Random writes are therefore issued after random gaps of up to 40 cycles, against slow periods of up to 512 cycles, so most writes land at an arbitrary counter phase. A per-cycle model then checks every tick from the restart onward. The mode lock needs pll_src_sel high at the same edge as a write to address 0. Directed writes produce this case, and the random stream sets the select independently on each write.

// File: rtl/cpb_pkg.sv
package cpb_pkg;

   localparam int unsigned BUS_W  = 8;
   localparam int unsigned ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      SEL_FAST = 2'd0,
      SEL_SLOW = 2'd1,
      SEL_AUX  = 2'd2,
      SEL_NONE = 2'd3
   } cpb_sel_e;

   localparam logic [BUS_W-1:0] FAST_INIT = 8'h4F;
   localparam logic [BUS_W-1:0] SLOW_INIT = 8'hB6;
   localparam logic [BUS_W-1:0] AUX_INIT  = 8'hFF;

   typedef struct packed {
      logic [2:0] mult;
      logic       bad;
   } cpb_mult_t;

endpackage

// File: rtl/cpb_regs.sv
module cpb_regs
   import cpb_pkg::*;
#(
   parameter int unsigned FDIV_W = 4,
   parameter int unsigned MODE_W = 3,
   parameter int unsigned SDIV_W = 8,
   parameter int unsigned ADIV_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [BUS_W-1:0]    wdata,
   input  logic                we,
   input  logic                pll_src_sel,
   output logic [BUS_W-1:0]    rdata,
   output logic [FDIV_W-1:0]   fdiv,
   output logic [MODE_W-1:0]   mode,
   output logic [SDIV_W-1:0]   sdiv,
   output logic [ADIV_W-1:0]   adiv1,
   output logic [ADIV_W-1:0]   adiv2,
   output logic                ld_fast,
   output logic                ld_slow,
   output logic                ld_aux
);

   localparam int unsigned MODE_LO = FDIV_W;
   localparam int unsigned MODE_HI = FDIV_W + MODE_W - 1;
   localparam int unsigned A2_LO   = ADIV_W;
   localparam int unsigned A2_HI   = 2 * ADIV_W - 1;

   initial begin
      if (FDIV_W + MODE_W >= BUS_W)
         $error("cpb_regs: fast register fields do not leave the top bit free");
      if (SDIV_W > BUS_W)
         $error("cpb_regs: slow divisor wider than the bus");
      if (2 * ADIV_W > BUS_W)
         $error("cpb_regs: two auxiliary divisors do not fit the bus");
   end

   cpb_sel_e sel;
   assign sel = cpb_sel_e'(addr);

   assign ld_fast = we && (sel == SEL_FAST);
   assign ld_slow = we && (sel == SEL_SLOW);
   assign ld_aux  = we && (sel == SEL_AUX);

   logic mode_wr;
   assign mode_wr = ld_fast && !pll_src_sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fdiv <= FAST_INIT[FDIV_W-1:0];
      end else if (ld_fast) begin
         fdiv <= wdata[FDIV_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode <= FAST_INIT[MODE_HI:MODE_LO];
      end else if (mode_wr) begin
         mode <= wdata[MODE_HI:MODE_LO];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sdiv <= SLOW_INIT[SDIV_W-1:0];
      end else if (ld_slow) begin
         sdiv <= wdata[SDIV_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         adiv1 <= AUX_INIT[ADIV_W-1:0];
         adiv2 <= AUX_INIT[A2_HI:A2_LO];
      end else if (ld_aux) begin
         adiv1 <= wdata[ADIV_W-1:0];
         adiv2 <= wdata[A2_HI:A2_LO];
      end
   end

   always_comb begin
      rdata = '0;
      unique case (sel)
         SEL_FAST: begin
            rdata[FDIV_W-1:0]      = fdiv;
            rdata[MODE_HI:MODE_LO] = mode;
         end
         SEL_SLOW: begin
            rdata[SDIV_W-1:0] = sdiv;
         end
         SEL_AUX: begin
            rdata[ADIV_W-1:0] = adiv1;
            rdata[A2_HI:A2_LO] = adiv2;
         end
         default: rdata = '0;
      endcase
   end

   // R6
   mode_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == SEL_FAST && pll_src_sel) |=> $stable(mode));

   // R2
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == SEL_FAST) |-> (rdata[BUS_W-1] == 1'b0));

   // R10
   no_reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == SEL_NONE) |=> ($stable(fdiv) && $stable(mode) &&
                                    $stable(sdiv) && $stable(adiv1) && $stable(adiv2)));

   // R10
   none_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == SEL_NONE) |-> (rdata == '0));

endmodule

// File: rtl/cpb_div.sv
module cpb_div #(
   parameter int unsigned DIV_W  = 4,
   parameter bit          DOUBLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   input  logic             load,
   output logic             tick
);

   localparam int unsigned CNT_W = DIV_W + (DOUBLE ? 1 : 0);

   initial begin
      if (DIV_W < 1 || DIV_W > 16)
         $error("cpb_div: DIV_W out of supported range");
   end

   logic [CNT_W-1:0] limit;
   logic [CNT_W-1:0] cnt;

   generate
      if (DOUBLE) begin : g_double
         assign limit = {div, 1'b1};
      end else begin : g_single
         assign limit = div;
      end
   endgenerate

   assign tick = (cnt == limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load || cnt >= limit) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R3 R4 R5
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= limit);

   // R9
   count_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !tick) |=> (cnt == $past(cnt) + 1'b1));

   // R4
   generate
      if (DOUBLE) begin : g_even_chk
         slow_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && !load) |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/cpb_mode_dec.sv
module cpb_mode_dec
   import cpb_pkg::*;
#(
   parameter int unsigned MODE_W = 3
) (
   input  logic [MODE_W-1:0] mode,
   output logic [2:0]        mult,
   output logic              bad
);

   initial begin
      if (MODE_W != 3)
         $error("cpb_mode_dec: mode code must be 3 bits");
   end

   cpb_mult_t res;

   always_comb begin
      res = '{mult: 3'd0, bad: 1'b1};
      unique case (mode)
         3'b011: res = '{mult: 3'd3, bad: 1'b0};
         3'b100: res = '{mult: 3'd4, bad: 1'b0};
         3'b101: res = '{mult: 3'd5, bad: 1'b0};
         default: res = '{mult: 3'd0, bad: 1'b1};
      endcase
   end

   assign mult = res.mult;
   assign bad  = res.bad;

endmodule

// File: rtl/clk_prescaler_bank.sv
module clk_prescaler_bank
   import cpb_pkg::*;
#(
   parameter int unsigned FDIV_W = 4,
   parameter int unsigned MODE_W = 3,
   parameter int unsigned SDIV_W = 8,
   parameter int unsigned ADIV_W = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  bus_addr,
   input  logic [7:0]  bus_wdata,
   input  logic        bus_we,
   output logic [7:0]  bus_rdata,
   input  logic        pll_src_sel,
   output logic        tick_fast,
   output logic        tick_slow,
   output logic        tick_aux1,
   output logic        tick_aux2,
   output logic [2:0]  pll_mult,
   output logic        pll_mode_bad
);

   localparam int unsigned N_AUX = 2;

   logic [FDIV_W-1:0] fdiv;
   logic [MODE_W-1:0] mode;
   logic [SDIV_W-1:0] sdiv;
   logic [ADIV_W-1:0] adiv [N_AUX];
   logic              ld_fast, ld_slow, ld_aux;
   logic [N_AUX-1:0]  aux_tick;

   cpb_regs #(
      .FDIV_W(FDIV_W), .MODE_W(MODE_W), .SDIV_W(SDIV_W), .ADIV_W(ADIV_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (bus_addr),
      .wdata      (bus_wdata),
      .we         (bus_we),
      .pll_src_sel(pll_src_sel),
      .rdata      (bus_rdata),
      .fdiv       (fdiv),
      .mode       (mode),
      .sdiv       (sdiv),
      .adiv1      (adiv[0]),
      .adiv2      (adiv[1]),
      .ld_fast    (ld_fast),
      .ld_slow    (ld_slow),
      .ld_aux     (ld_aux)
   );

   cpb_div #(.DIV_W(FDIV_W), .DOUBLE(1'b0)) u_div_fast (
      .clk(clk), .rst_n(rst_n), .div(fdiv), .load(ld_fast), .tick(tick_fast)
   );

   cpb_div #(.DIV_W(SDIV_W), .DOUBLE(1'b1)) u_div_slow (
      .clk(clk), .rst_n(rst_n), .div(sdiv), .load(ld_slow), .tick(tick_slow)
   );

   generate
      for (genvar i = 0; i < N_AUX; i++) begin : g_aux
         cpb_div #(.DIV_W(ADIV_W), .DOUBLE(1'b0)) u_div_aux (
            .clk(clk), .rst_n(rst_n), .div(adiv[i]), .load(ld_aux), .tick(aux_tick[i])
         );
      end
   endgenerate

   assign tick_aux1 = aux_tick[0];
   assign tick_aux2 = aux_tick[1];

   cpb_mode_dec #(.MODE_W(MODE_W)) u_dec (
      .mode(mode), .mult(pll_mult), .bad(pll_mode_bad)
   );

   // R8
   bad_means_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pll_mode_bad |-> (pll_mult == 3'd0));

   // R7
   good_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_mode_bad |-> (pll_mult >= 3'd3 && pll_mult <= 3'd5));

   // R3
   fast_zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fdiv == '0) |-> tick_fast);

endmodule

// File: tb/clk_prescaler_bank_tb.sv
module clk_prescaler_bank_tb;

   localparam int CLK_PERIOD   = 10;
   localparam int WATCHDOG_CYC = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_rdata;
   logic       pll_src_sel = 1'b0;
   logic       tick_fast, tick_slow, tick_aux1, tick_aux2;
   logic [2:0] pll_mult;
   logic       pll_mode_bad;

   int checks = 0;
   int errors = 0;
   bit chk_on = 1'b0;
   bit done = 1'b0;

   // shadow model
   int fc, md, sc, ac;
   int s_f, s_s, s_a;

   always #(CLK_PERIOD/2) clk = ~clk;

   clk_prescaler_bank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .pll_src_sel(pll_src_sel),
      .tick_fast(tick_fast), .tick_slow(tick_slow), .tick_aux1(tick_aux1),
      .tick_aux2(tick_aux2), .pll_mult(pll_mult), .pll_mode_bad(pll_mode_bad)
   );

   function automatic int exp_mult(int code);
      case (code)
         3: return 3;
         4: return 4;
         5: return 5;
         default: return 0;
      endcase
   endfunction

   function automatic bit exp_tick(int s, int p);
      return (s % p) == (p - 1);
   endfunction

   function automatic int exp_read(int a);
      case (a)
         0: return (md << 4) | fc;
         1: return sc;
         2: return ac;
         default: return 0;
      endcase
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         fc <= 15; md <= 4; sc <= 8'hB6; ac <= 8'hFF;
         s_f <= 0; s_s <= 0; s_a <= 0;
      end else begin
         s_f <= s_f + 1; s_s <= s_s + 1; s_a <= s_a + 1;
         if (bus_we) begin
            case (bus_addr)
               2'd0: begin
                  fc <= int'(bus_wdata[3:0]);
                  if (!pll_src_sel) md <= int'(bus_wdata[6:4]);
                  s_f <= 0;
               end
               2'd1: begin sc <= int'(bus_wdata); s_s <= 0; end
               2'd2: begin ac <= int'(bus_wdata); s_a <= 0; end
               default: ;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (chk_on) begin
         bit e;
         e = exp_tick(s_f, fc + 1);
         check(tick_fast == e, "R3 R9 tick_fast", int'(tick_fast), int'(e));
         e = exp_tick(s_s, 2 * (sc + 1));
         check(tick_slow == e, "R4 R9 tick_slow", int'(tick_slow), int'(e));
         e = exp_tick(s_a, (ac & 15) + 1);
         check(tick_aux1 == e, "R5 R9 tick_aux1", int'(tick_aux1), int'(e));
         e = exp_tick(s_a, (ac >> 4) + 1);
         check(tick_aux2 == e, "R5 R9 tick_aux2", int'(tick_aux2), int'(e));
         check(int'(pll_mult) == exp_mult(md), "R7 R8 pll_mult",
               int'(pll_mult), exp_mult(md));
         check(pll_mode_bad == (exp_mult(md) == 0), "R7 R8 pll_mode_bad",
               int'(pll_mode_bad), int'(exp_mult(md) == 0));
      end
   end

   task automatic wr(int a, int d, bit sel);
      @(negedge clk);
      bus_addr = 2'(a); bus_wdata = 8'(d); bus_we = 1'b1; pll_src_sel = sel;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(int a, string tag);
      @(negedge clk);
      bus_addr = 2'(a);
      #1;
      check(int'(bus_rdata) == exp_read(a), tag, int'(bus_rdata), exp_read(a));
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk_on = 1'b1;

      // R1 reset values
      rd(0, "R1 fast reset");
      check(int'(bus_rdata) == 8'h4F, "R1 fast 0x4F", int'(bus_rdata), 8'h4F);
      rd(1, "R1 slow reset");
      check(int'(bus_rdata) == 8'hB6, "R1 slow 0xB6", int'(bus_rdata), 8'hB6);
      rd(2, "R1 aux reset");
      check(int'(bus_rdata) == 8'hFF, "R1 aux 0xFF", int'(bus_rdata), 8'hFF);
      idle(40);

      // R2 top bit dropped, R8 reserved code 7, R3 divisor 0
      wr(0, 8'hF0, 1'b0);
      rd(0, "R2 fast fields");
      check(int'(bus_rdata) == 8'h70, "R2 bit7 reads 0", int'(bus_rdata), 8'h70);
      idle(6);

      // R4 slow divisor 0
      wr(1, 8'h00, 1'b0);
      idle(9);

      // R5 field placement
      wr(2, 8'h21, 1'b0);
      rd(2, "R5 aux fields");
      idle(12);

      // R6 mode locked while synthesiser is the source
      wr(0, 8'h35, 1'b1);
      rd(0, "R6 mode kept");
      check(int'(bus_rdata) == 8'h75, "R6 fdiv updated mode kept", int'(bus_rdata), 8'h75);

      // R7 valid codes, R8 reserved code
      wr(0, 8'h33, 1'b0); idle(5);
      wr(0, 8'h42, 1'b0); idle(5);
      wr(0, 8'h51, 1'b0); idle(5);
      wr(0, 8'h14, 1'b0); idle(5);
      check(pll_mode_bad == 1'b1, "R8 code 001 flagged", int'(pll_mode_bad), 1);

      // R10 unused address
      wr(3, 8'hA5, 1'b0);
      rd(3, "R10 addr3 zero");
      rd(0, "R10 fast untouched");
      rd(1, "R10 slow untouched");
      rd(2, "R10 aux untouched");

      // R9 restart mid period
      wr(1, 8'h09, 1'b0); idle(7);
      wr(1, 8'h04, 1'b0); idle(14);
      wr(2, 8'hF7, 1'b0); idle(3);
      wr(2, 8'h3C, 1'b0); idle(20);

      // constrained random
      for (int i = 0; i < 400; i++) begin
         int a;
         a = int'($urandom_range(0, 3));
         wr(a, int'($urandom_range(0, 255)), bit'($urandom_range(0, 1)));
         if ($urandom_range(0, 3) == 0) rd(int'($urandom_range(0, 3)), "R1 R2 R10 random read");
         idle(int'($urandom_range(0, 40)));
      end

      chk_on = 1'b0;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired, actual=running expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule